// File: doc/BRIEF.md
# 32-bit Shift and Rotate Unit

This block is the shift path of a RISC integer ALU. On each accepted operation it takes an operand word A, a second register operand B and a 5-bit immediate, and it produces one of five results: a logical left shift, a logical right shift, an arithmetic right shift, a rotate left or a rotate right. The result is registered, so it appears one clock after the request, and it is flagged by a valid bit.

The shift or rotate count comes either from a small immediate field or from the low bits of operand B, chosen by a source-select bit. Shifts and rotates mask a register count in different ways. A register shift uses six bits of B, so counts of 32 to 63 push every bit of A out of the word. A rotate uses only five bits, so its count wraps at the word size.

The control is a two-state machine. In `SRU_EMPTY` the output holds nothing new. In `SRU_FULL` the output register holds a result from the previous cycle. The transition `ACCEPT` (in_valid high) enters `SRU_FULL` from either state. The transition `DRAIN` (in_valid low) enters `SRU_EMPTY` from either state. Reset forces `SRU_EMPTY`.

Top module: `shift_rotate_unit`

## Requirements
- R1: While rst_n is low and in the first cycle after reset, out_valid is 0 and out_data is 0.
- R2: out_valid is 1 exactly in the cycle after a cycle with in_valid high. out_data changes only after a cycle with in_valid high and otherwise holds its value.
- R3: op_code 3'b000 is the logical left shift. Vacated low bits are filled with 0.
- R4: op_code 3'b001 is the logical right shift. Vacated high bits are filled with 0.
- R5: op_code 3'b010 is the arithmetic right shift. Vacated high bits are filled with copies of a_data[31].
- R6: When amt_is_imm is 0, a shift takes its count from b_data[5:0]. Bits b_data[31:6] have no effect on the result.
- R7: For a register shift count of 32 to 63, both logical shifts return 0. The arithmetic right shift returns 32'hFFFF_FFFF when a_data[31] is 1 and 0 otherwise.
- R8: When amt_is_imm is 1, every operation takes its count from imm_amt[4:0], and b_data has no effect on the result.
- R9: op_code 3'b011 rotates left and op_code 3'b100 rotates right. With a register source, a rotate uses only b_data[4:0], so b_data[5] has no effect.
- R10: A rotate by 0 returns a_data unchanged. A rotate right by n gives the same result as a rotate left by (32-n) mod 32.
- R11: op_codes 3'b101, 3'b110 and 3'b111 return a_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| op_code | input | 3 | Operation select (see R3, R4, R5, R9, R11) |
| amt_is_imm | input | 1 | 1: count from imm_amt, 0: count from b_data |
| a_data | input | 32 | Operand to shift or rotate |
| b_data | input | 32 | Register count source |
| imm_amt | input | 5 | Immediate count field |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_data | output | 32 | Registered result |

## Verification
The bench targets the register count boundary at 31, 32 and 63. A design that masked shifts to five bits would return a shifted word there instead of a flushed one, and a design that flushed rotates would return 0 instead of a rotated word. It drives garbage in b_data[31:6], and in all of b_data for immediate operations. A design that decoded too many bits would then produce a wrong result. Arithmetic shifts are driven with both signs of operand, so a sign fill tied to the wrong bit shows up as a wrong high bit. The bench also uses rotate counts of 0 and 31, rotate-right equivalence pairs, unused op codes, and idle cycles. A design that updated out_data without a request, or that misplaced the one-cycle valid, would differ from the reference model on the next clock.

// File: rtl/sru_pkg.sv
package sru_pkg;
    localparam logic [2:0] OPC_SLL = 3'b000;
    localparam logic [2:0] OPC_SRL = 3'b001;
    localparam logic [2:0] OPC_SRA = 3'b010;
    localparam logic [2:0] OPC_ROL = 3'b011;
    localparam logic [2:0] OPC_ROR = 3'b100;

    typedef enum logic {
        SRU_EMPTY = 1'b0,
        SRU_FULL  = 1'b1
    } sru_state_e;
endpackage

// File: rtl/sru_amount.sv
module sru_amount #(
    parameter int AMT_W = 5
) (
    input  logic             amt_is_imm,
    input  logic             is_rotate,
    input  logic [AMT_W:0]   reg_amt,
    input  logic [AMT_W-1:0] imm_amt,
    output logic [AMT_W-1:0] amt,
    output logic             flush
);
    // Register shifts see one extra count bit; set means the whole word leaves.
    always_comb begin
        if (amt_is_imm) begin
            amt   = imm_amt;
            flush = 1'b0;
        end else begin
            amt   = reg_amt[AMT_W-1:0];
            flush = !is_rotate && reg_amt[AMT_W];
        end
    end
endmodule

// File: rtl/sru_core.sv
module sru_core
    import sru_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [2:0]       op_code,
    input  logic [AMT_W-1:0] amt,
    input  logic             flush,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] result
);
    logic dir_left;
    logic is_rot;
    logic is_known;
    logic fill_bit;

    assign dir_left = (op_code == OPC_SLL) || (op_code == OPC_ROL);
    assign is_rot   = (op_code == OPC_ROL) || (op_code == OPC_ROR);
    assign is_known = (op_code <= OPC_ROR);
    assign fill_bit = (op_code == OPC_SRA) ? a_in[WIDTH-1] : 1'b0;

    logic [WIDTH-1:0] a_rev;
    logic [WIDTH-1:0] src;
    logic [WIDTH-1:0] out_rev;
    logic [AMT_W:0][WIDTH-1:0] stg;

    // Left operations run through the right-moving network on a mirrored word.
    for (genvar j = 0; j < WIDTH; j++) begin : g_rev
        assign a_rev[j]   = a_in[WIDTH-1-j];
        assign out_rev[j] = stg[AMT_W][WIDTH-1-j];
    end

    assign src    = dir_left ? a_rev : a_in;
    assign stg[0] = src;

    for (genvar i = 0; i < AMT_W; i++) begin : g_stage
        localparam int S = 1 << i;
        logic [WIDTH-1:0] moved;
        assign moved = is_rot ? {stg[i][S-1:0], stg[i][WIDTH-1:S]}
                              : {{S{fill_bit}}, stg[i][WIDTH-1:S]};
        assign stg[i+1] = amt[i] ? moved : stg[i];
    end

    always_comb begin
        if (!is_known) begin
            result = a_in;
        end else if (flush) begin
            result = {WIDTH{fill_bit}};
        end else if (dir_left) begin
            result = out_rev;
        end else begin
            result = stg[AMT_W];
        end
    end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import sru_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       op_code,
    input  logic             amt_is_imm,
    input  logic [WIDTH-1:0] a_data,
    input  logic [WIDTH-1:0] b_data,
    input  logic [AMT_W-1:0] imm_amt,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data
);
    sru_state_e       state_q;
    sru_state_e       state_d;
    logic [AMT_W-1:0] amt;
    logic             flush;
    logic             is_rotate;
    logic [WIDTH-1:0] result;

    assign is_rotate = (op_code == OPC_ROL) || (op_code == OPC_ROR);

    sru_amount #(.AMT_W(AMT_W)) u_amount (
        .amt_is_imm (amt_is_imm),
        .is_rotate  (is_rotate),
        .reg_amt    (b_data[AMT_W:0]),
        .imm_amt    (imm_amt),
        .amt        (amt),
        .flush      (flush)
    );

    sru_core #(.WIDTH(WIDTH)) u_core (
        .op_code (op_code),
        .amt     (amt),
        .flush   (flush),
        .a_in    (a_data),
        .result  (result)
    );

    // Transitions: ACCEPT on in_valid, DRAIN otherwise.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRU_EMPTY: state_d = in_valid ? SRU_FULL : SRU_EMPTY;
            SRU_FULL:  state_d = in_valid ? SRU_FULL : SRU_EMPTY;
            default:   state_d = SRU_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SRU_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
        end else if (in_valid) begin
            out_data <= result;
        end
    end

    assign out_valid = (state_q == SRU_FULL);
endmodule

// File: rtl/sru_checker.sv
module sru_checker
    import sru_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       op_code,
    input logic             amt_is_imm,
    input logic [WIDTH-1:0] a_data,
    input logic [WIDTH-1:0] b_data,
    input logic [AMT_W-1:0] imm_amt,
    input logic             out_valid,
    input logic [WIDTH-1:0] out_data
);
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));

    p_logic_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !amt_is_imm && b_data[AMT_W] &&
         (op_code == OPC_SLL || op_code == OPC_SRL)) |=> (out_data == '0));

    p_sign_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !amt_is_imm && b_data[AMT_W] && op_code == OPC_SRA)
        |=> (out_data == {WIDTH{$past(a_data[WIDTH-1])}}));

    p_rot_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_code == OPC_ROL || op_code == OPC_ROR) &&
         amt_is_imm && imm_amt == '0) |=> (out_data == $past(a_data)));

    p_unused_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code > OPC_ROR) |=> (out_data == $past(a_data)));
endmodule

bind shift_rotate_unit sru_checker #(.WIDTH(WIDTH)) u_sru_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_code    (op_code),
    .amt_is_imm (amt_is_imm),
    .a_data     (a_data),
    .b_data     (b_data),
    .imm_amt    (imm_amt),
    .out_valid  (out_valid),
    .out_data   (out_data)
);

// File: tb/shift_rotate_unit_tb.sv
module shift_rotate_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_code = 3'b000;
    logic        amt_is_imm = 1'b0;
    logic [31:0] a_data = '0;
    logic [31:0] b_data = '0;
    logic [4:0]  imm_amt = '0;
    logic        out_valid;
    logic [31:0] out_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit        exp_valid = 1'b0;
    bit [31:0] exp_data = '0;

    always #4 clk = ~clk;

    shift_rotate_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .amt_is_imm(amt_is_imm), .a_data(a_data), .b_data(b_data),
        .imm_amt(imm_amt), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic bit [31:0] ref_model(input bit [2:0] op, input bit imm_sel,
                                            input bit [31:0] a, input bit [31:0] b,
                                            input bit [4:0] imm);
        int n;
        bit [63:0] wide;
        longint sa;
        if (op > 3'd4) return a;
        if (imm_sel) n = imm;
        else if (op >= 3'd3) n = b % 32;
        else n = b % 64;
        case (op)
            3'd0: begin wide = {32'b0, a} << n; return wide[31:0]; end
            3'd1: begin wide = {32'b0, a} >> n; return wide[31:0]; end
            3'd2: begin sa = longint'(signed'(a)); sa = sa >>> n; return sa[31:0]; end
            3'd3: begin wide = {a, a} << n; return wide[63:32]; end
            default: begin wide = {a, a} >> n; return wide[31:0]; end
        endcase
    endfunction

    task automatic check(input string tag, input bit [31:0] act, input bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit v, input bit [2:0] op,
                        input bit imm_sel, input bit [31:0] a, input bit [31:0] b,
                        input bit [4:0] imm);
        in_valid = v; op_code = op; amt_is_imm = imm_sel;
        a_data = a; b_data = b; imm_amt = imm;
        @(posedge clk);
        exp_valid = v;
        if (v) exp_data = ref_model(op, imm_sel, a, b, imm);
        @(negedge clk);
        check({tag, " valid (R2)"}, {31'b0, out_valid}, {31'b0, exp_valid});
        check(tag, out_data, exp_data);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", {31'b0, out_valid}, 32'd0);
        check("R1 reset data", out_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset valid", {31'b0, out_valid}, 32'd0);
        check("R1 after reset data", out_data, 32'd0);

        step("R3 sll 4",       1, 3'd0, 0, 32'h8000_00F1, 32'h0000_0004, 5'd0);
        step("R3 sll 31",      1, 3'd0, 0, 32'h0000_0003, 32'd31, 5'd0);
        step("R4 srl 8",       1, 3'd1, 0, 32'hF000_1234, 32'd8, 5'd0);
        step("R5 sra neg",     1, 3'd2, 0, 32'h8000_0010, 32'd4, 5'd0);
        step("R5 sra pos",     1, 3'd2, 0, 32'h7000_0010, 32'd4, 5'd0);
        step("R6 high b bits", 1, 3'd1, 0, 32'hABCD_EF01, 32'hFFFF_FFC4, 5'd0);
        step("R7 sll 32",      1, 3'd0, 0, 32'hFFFF_FFFF, 32'd32, 5'd0);
        step("R7 srl 63",      1, 3'd1, 0, 32'hFFFF_FFFF, 32'd63, 5'd0);
        step("R7 sra 40 neg",  1, 3'd2, 0, 32'h8000_0000, 32'd40, 5'd0);
        step("R7 sra 32 pos",  1, 3'd2, 0, 32'h7FFF_FFFF, 32'd32, 5'd0);
        step("R8 imm sll",     1, 3'd0, 1, 32'h0000_00FF, 32'hFFFF_FFFF, 5'd12);
        step("R8 imm sra",     1, 3'd2, 1, 32'h8765_4321, 32'd63, 5'd31);
        step("R9 rol reg b5",  1, 3'd3, 0, 32'h1234_5678, 32'h0000_0024, 5'd0);
        step("R9 ror reg",     1, 3'd4, 0, 32'h1234_5678, 32'hFFFF_FFE8, 5'd0);
        step("R10 rol 0",      1, 3'd3, 1, 32'hDEAD_BEEF, 32'd5, 5'd0);
        step("R10 ror 0 reg",  1, 3'd4, 0, 32'hDEAD_BEEF, 32'd32, 5'd0);
        step("R10 rol 31",     1, 3'd3, 1, 32'h8000_0001, 32'd0, 5'd31);
        step("R10 ror 5",      1, 3'd4, 1, 32'h0000_001F, 32'd0, 5'd5);
        step("R10 rol 27",     1, 3'd3, 1, 32'h0000_001F, 32'd0, 5'd27);
        check("R10 ror5 equals rol27", out_data, 32'hF800_0000);
        step("R11 code 5",     1, 3'd5, 0, 32'hCAFE_F00D, 32'd3, 5'd3);
        step("R11 code 7",     1, 3'd7, 1, 32'h0BAD_CAFE, 32'd9, 5'd9);
        step("R2 idle hold",   0, 3'd0, 0, 32'hFFFF_FFFF, 32'd1, 5'd1);
        step("R2 idle hold2",  0, 3'd1, 1, 32'h1111_1111, 32'd2, 5'd2);
        step("R4 srl imm 1",   1, 3'd1, 1, 32'h8000_0000, 32'd40, 5'd1);
        for (int k = 0; k < 200; k++) begin
            step("R6 sweep", 1, 3'(k % 8), 1'(k % 3 == 0),
                 32'(k * 32'h9E37_79B9), 32'(k * 32'h85EB_CA6B), 5'(k * 7));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule